// File: doc/BRIEF.md
# NAND Page Array Engine

This block is the storage side of a NAND flash model. It sits behind a command decoder and holds a small on-chip cell array. The array is organised as pages. Each page carries a spare area of one thirty-second of its data size, and pages are grouped into erase blocks. The decoder asks the engine to act through a request/acknowledge pair. The engine can fill a page buffer from the array, program the buffer contents into a page, erase the block around a page, or empty the program buffer. A byte-wide read port streams the loaded page out of the buffer, and a byte-wide write port collects program data into it.

Cells behave like flash. Power-up and erase leave every byte at 0xFF. Programming can only clear bits, because each buffered byte is ANDed into the stored byte. Sequential reading continues across page boundaries: once a loaded page is exhausted, the engine fetches the next page on its own. The number of pages, the page size and the block size are parameters.

Top module: `nand_page_engine`

## Requirements
- R1: After reset, `ready` stays low while every byte of the array (data and spare) is written to 0xFF. No `ack` is given for this fill. The spare area of a page is PAGE_BYTES/32 bytes, so a row holds PAGE_BYTES + PAGE_BYTES/32 bytes.
- R2: A request is taken only when `ready` is high. In the cycle after a request is taken, `ready` is low. `ack` is a one-cycle pulse, high in the first cycle that `ready` is high again, and every request gets exactly one `ack`.
- R3: Op code 3 (clear) empties the program buffer. While `ready` is high, each `wr_en` appends `wr_data` to the buffer only if it holds fewer than one row of bytes. Further bytes are dropped and do not replace earlier ones.
- R4: Op code 1 (program) ANDs buffered byte k into the cell at column `req_col`+k of page `req_page`, for every buffered k. It stops at the end of the row.
- R5: Op code 2 (erase) clears the low ERASE_SHIFT bits of `req_page` and sets every data and spare byte of the 2^ERASE_SHIFT pages from that page up to 0xFF. Other pages are left unchanged.
- R6: A load, program or erase with `req_page` at or above NUM_PAGES changes neither the array, nor the buffer, nor the read position. It is still acknowledged.
- R7: Op code 0 (load) copies the page row into the buffer. Reading starts at the sum of `req_col` and `req_skip`. The number of readable bytes is the row size minus that start, or PAGE_BYTES minus that start when `hide_spare` is high at request time, and never less than zero.
- R8: A strobe on `rd_en` with `ce_n` low, `ready` high and bytes remaining returns the next buffered byte on `rd_data` after the clock edge. The read position then advances by one.
- R9: A strobe with `ce_n` high returns 0x00 and consumes no byte. A strobe with no bytes remaining also returns 0x00.
- R10: After a load, a strobe with `ce_n` low and no bytes remaining starts a reload of the next page from column 0 with no skip, using the current `hide_spare`. `ready` drops during the reload and no `ack` follows it. If the next page does not exist, nothing starts and `ready` stays high.
- R11: `rd_data` holds its value in every cycle without a taken read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe from the decoder |
| req_op | input | 2 | 0 load, 1 program, 2 erase, 3 clear buffer |
| req_page | input | PAGE_AW | Page number |
| req_col | input | CNT_W | Starting column within the row |
| req_skip | input | CNT_W | Extra read offset added to the column on load |
| hide_spare | input | 1 | Limit reads to the data area |
| ready | output | 1 | Engine idle, request and port strobes taken |
| ack | output | 1 | One-cycle completion pulse |
| ce_n | input | 1 | Active-low chip enable for the read port |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Byte returned by the last read strobe |
| wr_en | input | 1 | Program-data strobe |
| wr_data | input | 8 | Program-data byte |

## Verification
On every cycle, the assertions check the handshake: the busy cycle after each request, `ack` only alongside `ready`, and `ack` lasting a single cycle. They also check that a disabled read returns zero, that `rd_data` holds between strobes, and that the program-buffer count never passes one row and grows by one per accepted byte. Only the bench scenarios can show the array contents. These cover AND-merging of programs, block alignment of erase, the 0xFF fill, the readable length under column, skip and spare masking, the automatic next-page reload, and the out-of-range no-ops. The bench checks them against a byte model of the array.

// File: rtl/nand_arr_pkg.sv
package nand_arr_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_CLEAR = 2'd3
   } arr_op_e;

   typedef enum logic [2:0] {
      ST_FILL,
      ST_IDLE,
      ST_START,
      ST_LOAD,
      ST_PROG_RD,
      ST_PROG_WR,
      ST_ERASE
   } eng_state_e;

   localparam int SPARE_SHIFT = 5;

endpackage

// File: rtl/nand_arr_store.sv
module nand_arr_store #(
   parameter int DEPTH = 2112,
   parameter int AW    = 13
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [7:0] cells [DEPTH];
   logic       hit;

   assign hit = ({1'b0, addr} < (AW+1)'(DEPTH));

   always_ff @(posedge clk) begin
      if (we && hit) begin
         cells[addr[IW-1:0]] <= wdata;
      end
      rdata <= hit ? cells[addr[IW-1:0]] : 8'hFF;
   end
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
   parameter int DEPTH = 264,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [7:0]    rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [7:0]    rdata_b
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [7:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (we && ({1'b0, waddr} < (AW+1)'(DEPTH))) begin
         slots[waddr[IW-1:0]] <= wdata;
      end
   end

   assign rdata_a = ({1'b0, raddr_a} < (AW+1)'(DEPTH)) ? slots[raddr_a[IW-1:0]] : 8'h00;
   assign rdata_b = ({1'b0, raddr_b} < (AW+1)'(DEPTH)) ? slots[raddr_b[IW-1:0]] : 8'h00;
endmodule

// File: rtl/nand_arr_ctrl.sv
module nand_arr_ctrl
   import nand_arr_pkg::*;
#(
   parameter int PAGE_BYTES = 256,
   parameter int NUM_PAGES  = 8,
   parameter int ROW_BYTES  = 264,
   parameter int BLK_PAGES  = 2,
   parameter int BLK_BYTES  = 528,
   parameter int ARR_BYTES  = 2112,
   parameter int CNT_W      = 10,
   parameter int PAGE_AW    = 4,
   parameter int ARR_AW     = 13,
   parameter int IDX_W      = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [PAGE_AW-1:0] req_page,
   input  logic [CNT_W-1:0]   req_col,
   input  logic [CNT_W-1:0]   req_skip,
   input  logic               hide_spare,
   output logic               ready,
   output logic               ack,
   input  logic               ce_n,
   input  logic               rd_en,
   output logic [7:0]         rd_data,
   input  logic               wr_en,
   input  logic [7:0]         wr_data,
   output logic [CNT_W-1:0]   prog_cnt,
   output logic [ARR_AW-1:0]  m_addr,
   output logic               m_we,
   output logic [7:0]         m_wdata,
   input  logic [7:0]         m_rdata,
   output logic               b_we,
   output logic [CNT_W-1:0]   b_waddr,
   output logic [7:0]         b_wdata,
   output logic [CNT_W-1:0]   b_raddr_a,
   input  logic [7:0]         b_rdata_a,
   output logic [CNT_W-1:0]   b_raddr_b,
   input  logic [7:0]         b_rdata_b
);
   eng_state_e         state_q;
   arr_op_e            op_q;
   logic [IDX_W-1:0]   idx_q;
   logic [PAGE_AW-1:0] page_q;
   logic [CNT_W-1:0]   col_q, skip_q;
   logic               hide_q, ack_pend_q, rmode_q, ack_q;
   logic [CNT_W-1:0]   wcnt_q, ptr_q, rem_q;
   logic [7:0]         rd_q;

   logic [ARR_AW-1:0]  row_base, blk_base, prog_addr;
   logic [PAGE_AW-1:0] blk_page;
   logic               page_ok, next_ok, prog_last, rd_take, wr_take;
   logic [IDX_W:0]     nxt_idx;
   logic [CNT_W:0]     start_w, limit_w, avail_w;

   assign blk_page  = page_q & ~PAGE_AW'(BLK_PAGES - 1);
   assign row_base  = ARR_AW'(page_q) * ARR_AW'(ROW_BYTES);
   assign blk_base  = ARR_AW'(blk_page) * ARR_AW'(ROW_BYTES);
   assign prog_addr = row_base + ARR_AW'(col_q) + ARR_AW'(idx_q);
   assign page_ok   = ({1'b0, page_q} < (PAGE_AW+1)'(NUM_PAGES));
   assign next_ok   = (({1'b0, page_q} + (PAGE_AW+1)'(1)) < (PAGE_AW+1)'(NUM_PAGES));
   assign nxt_idx   = {1'b0, idx_q} + (IDX_W+1)'(1);
   assign prog_last = (nxt_idx >= (IDX_W+1)'(wcnt_q)) ||
                      ((nxt_idx + (IDX_W+1)'(col_q)) >= (IDX_W+1)'(ROW_BYTES));

   assign start_w = {1'b0, col_q} + {1'b0, skip_q};
   assign limit_w = hide_q ? (CNT_W+1)'(PAGE_BYTES) : (CNT_W+1)'(ROW_BYTES);
   assign avail_w = (start_w < limit_w) ? (limit_w - start_w) : '0;

   assign rd_take = (state_q == ST_IDLE) && !req_valid && rd_en;
   assign wr_take = (state_q == ST_IDLE) && !req_valid && wr_en &&
                    (wcnt_q < CNT_W'(ROW_BYTES));

   // Memory and buffer port steering
   always_comb begin
      m_addr    = '0;
      m_we      = 1'b0;
      m_wdata   = 8'hFF;
      b_we      = wr_take;
      b_waddr   = wcnt_q;
      b_wdata   = wr_data;
      b_raddr_a = ptr_q;
      b_raddr_b = CNT_W'(idx_q);
      case (state_q)
         ST_FILL: begin
            m_we   = 1'b1;
            m_addr = ARR_AW'(idx_q);
         end
         ST_LOAD: begin
            m_addr  = row_base + ARR_AW'(idx_q);
            b_we    = (idx_q != '0);
            b_waddr = CNT_W'(idx_q - IDX_W'(1));
            b_wdata = m_rdata;
         end
         ST_PROG_RD: begin
            m_addr = prog_addr;
         end
         ST_PROG_WR: begin
            m_addr  = prog_addr;
            m_we    = 1'b1;
            m_wdata = m_rdata & b_rdata_b;
         end
         ST_ERASE: begin
            m_addr = blk_base + ARR_AW'(idx_q);
            m_we   = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_FILL;
         op_q       <= OP_LOAD;
         idx_q      <= '0;
         page_q     <= '0;
         col_q      <= '0;
         skip_q     <= '0;
         hide_q     <= 1'b0;
         ack_pend_q <= 1'b0;
         rmode_q    <= 1'b0;
         ack_q      <= 1'b0;
         wcnt_q     <= '0;
         ptr_q      <= '0;
         rem_q      <= '0;
         rd_q       <= 8'h00;
      end else begin
         ack_q <= 1'b0;
         case (state_q)
            ST_FILL: begin
               if (idx_q == IDX_W'(ARR_BYTES - 1)) begin
                  idx_q   <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            ST_IDLE: begin
               if (req_valid) begin
                  op_q       <= arr_op_e'(req_op);
                  page_q     <= req_page;
                  col_q      <= req_col;
                  skip_q     <= req_skip;
                  hide_q     <= hide_spare;
                  ack_pend_q <= 1'b1;
                  state_q    <= ST_START;
               end else begin
                  if (wr_take) begin
                     wcnt_q <= wcnt_q + CNT_W'(1);
                  end
                  if (rd_take) begin
                     if (ce_n) begin
                        rd_q <= 8'h00;
                     end else if (rem_q != '0) begin
                        rd_q  <= b_rdata_a;
                        ptr_q <= ptr_q + CNT_W'(1);
                        rem_q <= rem_q - CNT_W'(1);
                     end else begin
                        rd_q <= 8'h00;
                        if (rmode_q && next_ok) begin
                           page_q     <= page_q + PAGE_AW'(1);
                           col_q      <= '0;
                           skip_q     <= '0;
                           hide_q     <= hide_spare;
                           ack_pend_q <= 1'b0;
                           idx_q      <= '0;
                           state_q    <= ST_LOAD;
                        end
                     end
                  end
               end
            end
            ST_START: begin
               idx_q <= '0;
               if (!page_ok && (op_q != OP_CLEAR)) begin
                  state_q <= ST_IDLE;
                  ack_q   <= ack_pend_q;
               end else begin
                  case (op_q)
                     OP_LOAD: begin
                        rmode_q <= 1'b1;
                        state_q <= ST_LOAD;
                     end
                     OP_PROG: begin
                        rmode_q <= 1'b0;
                        if ((wcnt_q == '0) || (col_q >= CNT_W'(ROW_BYTES))) begin
                           state_q <= ST_IDLE;
                           ack_q   <= ack_pend_q;
                        end else begin
                           state_q <= ST_PROG_RD;
                        end
                     end
                     OP_ERASE: begin
                        rmode_q <= 1'b0;
                        state_q <= ST_ERASE;
                     end
                     default: begin
                        rmode_q <= 1'b0;
                        wcnt_q  <= '0;
                        state_q <= ST_IDLE;
                        ack_q   <= ack_pend_q;
                     end
                  endcase
               end
            end
            ST_LOAD: begin
               if (idx_q == IDX_W'(ROW_BYTES)) begin
                  ptr_q   <= CNT_W'(start_w);
                  rem_q   <= CNT_W'(avail_w);
                  state_q <= ST_IDLE;
                  ack_q   <= ack_pend_q;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            ST_PROG_RD: begin
               state_q <= ST_PROG_WR;
            end
            ST_PROG_WR: begin
               if (prog_last) begin
                  state_q <= ST_IDLE;
                  ack_q   <= ack_pend_q;
               end else begin
                  idx_q   <= idx_q + IDX_W'(1);
                  state_q <= ST_PROG_RD;
               end
            end
            ST_ERASE: begin
               if (idx_q == IDX_W'(BLK_BYTES - 1)) begin
                  state_q <= ST_IDLE;
                  ack_q   <= ack_pend_q;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready    = (state_q == ST_IDLE);
   assign ack      = ack_q;
   assign rd_data  = rd_q;
   assign prog_cnt = wcnt_q;
endmodule

// File: rtl/nand_page_engine.sv
module nand_page_engine
   import nand_arr_pkg::*;
#(
   parameter int PAGE_BYTES  = 256,
   parameter int NUM_PAGES   = 8,
   parameter int ERASE_SHIFT = 1,
   localparam int SPARE_BYTES = PAGE_BYTES >> SPARE_SHIFT,
   localparam int ROW_BYTES   = PAGE_BYTES + SPARE_BYTES,
   localparam int CNT_W       = $clog2(ROW_BYTES) + 1,
   localparam int PAGE_AW     = $clog2(NUM_PAGES) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [PAGE_AW-1:0] req_page,
   input  logic [CNT_W-1:0]   req_col,
   input  logic [CNT_W-1:0]   req_skip,
   input  logic               hide_spare,
   output logic               ready,
   output logic               ack,
   input  logic               ce_n,
   input  logic               rd_en,
   output logic [7:0]         rd_data,
   input  logic               wr_en,
   input  logic [7:0]         wr_data
);
   localparam int BLK_PAGES = 1 << ERASE_SHIFT;
   localparam int BLK_BYTES = BLK_PAGES * ROW_BYTES;
   localparam int ARR_BYTES = NUM_PAGES * ROW_BYTES;
   localparam int ARR_AW    = $clog2(ARR_BYTES) + 1;
   localparam int IDX_W     = $clog2(ARR_BYTES) + 1;

   generate
      if ((PAGE_BYTES < (1 << SPARE_SHIFT)) || ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0)) begin : g_bad_page
         initial $fatal(1, "page size must be a power of two of at least 32 bytes");
      end
      if ((NUM_PAGES < BLK_PAGES) || ((NUM_PAGES % BLK_PAGES) != 0)) begin : g_bad_blocks
         initial $fatal(1, "page count must be a whole number of erase blocks");
      end
   endgenerate

   logic [ARR_AW-1:0] m_addr;
   logic              m_we;
   logic [7:0]        m_wdata, m_rdata;
   logic              b_we;
   logic [CNT_W-1:0]  b_waddr, b_raddr_a, b_raddr_b;
   logic [7:0]        b_wdata, b_rdata_a, b_rdata_b;
   logic [CNT_W-1:0]  prog_cnt;

   nand_arr_ctrl #(
      .PAGE_BYTES (PAGE_BYTES),
      .NUM_PAGES  (NUM_PAGES),
      .ROW_BYTES  (ROW_BYTES),
      .BLK_PAGES  (BLK_PAGES),
      .BLK_BYTES  (BLK_BYTES),
      .ARR_BYTES  (ARR_BYTES),
      .CNT_W      (CNT_W),
      .PAGE_AW    (PAGE_AW),
      .ARR_AW     (ARR_AW),
      .IDX_W      (IDX_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_page   (req_page),
      .req_col    (req_col),
      .req_skip   (req_skip),
      .hide_spare (hide_spare),
      .ready      (ready),
      .ack        (ack),
      .ce_n       (ce_n),
      .rd_en      (rd_en),
      .rd_data    (rd_data),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .prog_cnt   (prog_cnt),
      .m_addr     (m_addr),
      .m_we       (m_we),
      .m_wdata    (m_wdata),
      .m_rdata    (m_rdata),
      .b_we       (b_we),
      .b_waddr    (b_waddr),
      .b_wdata    (b_wdata),
      .b_raddr_a  (b_raddr_a),
      .b_rdata_a  (b_rdata_a),
      .b_raddr_b  (b_raddr_b),
      .b_rdata_b  (b_rdata_b)
   );

   nand_arr_store #(
      .DEPTH (ARR_BYTES),
      .AW    (ARR_AW)
   ) u_store (
      .clk   (clk),
      .we    (m_we),
      .addr  (m_addr),
      .wdata (m_wdata),
      .rdata (m_rdata)
   );

   nand_page_buf #(
      .DEPTH (ROW_BYTES),
      .AW    (CNT_W)
   ) u_buf (
      .clk     (clk),
      .we      (b_we),
      .waddr   (b_waddr),
      .wdata   (b_wdata),
      .raddr_a (b_raddr_a),
      .rdata_a (b_rdata_a),
      .raddr_b (b_raddr_b),
      .rdata_b (b_rdata_b)
   );
endmodule

// File: rtl/nand_page_engine_chk.sv
module nand_page_engine_chk #(
   parameter int CNT_W     = 10,
   parameter int ROW_BYTES = 264
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             ready,
   input logic             ack,
   input logic             rd_en,
   input logic             ce_n,
   input logic [7:0]       rd_data,
   input logic             wr_en,
   input logic [CNT_W-1:0] prog_cnt
);
   p_ack_with_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ready);

   p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready) |=> (!ready && !ack));

   p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   p_ce_high_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !req_valid && rd_en && ce_n) |=> (rd_data == 8'h00));

   p_hold_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && !req_valid && rd_en) |=> $stable(rd_data));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_cnt <= CNT_W'(ROW_BYTES));

   p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !req_valid && wr_en && (prog_cnt < CNT_W'(ROW_BYTES)))
      |=> (prog_cnt == $past(prog_cnt) + CNT_W'(1)));
endmodule

bind nand_page_engine nand_page_engine_chk #(
   .CNT_W     (CNT_W),
   .ROW_BYTES (ROW_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .ready     (ready),
   .ack       (ack),
   .rd_en     (rd_en),
   .ce_n      (ce_n),
   .rd_data   (rd_data),
   .wr_en     (wr_en),
   .prog_cnt  (prog_cnt)
);

// File: tb/nand_page_engine_test.sv
module nand_page_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int PG   = 256;
   localparam int ROW  = 264;
   localparam int NP   = 8;
   localparam int BLKP = 2;
   localparam int NV   = 6;

   // program/readback vectors: page, column, byte count, seed, read back
   localparam int V_PAGE [NV] = '{2, 2, 3, 5, 6, 9};
   localparam int V_COL  [NV] = '{0, 8, 250, 0, 0, 0};
   localparam int V_CNT  [NV] = '{16, 16, 20, 270, 1, 4};
   localparam int V_SEED [NV] = '{8'hA5, 8'h3C, 8'h0F, 8'h5A, 8'h12, 8'h00};
   localparam int V_RB   [NV] = '{1, 1, 1, 1, 1, 0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [3:0] req_page = '0;
   logic [9:0] req_col = '0;
   logic [9:0] req_skip = '0;
   logic       hide_spare = 1'b0;
   logic       ready, ack;
   logic       ce_n = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;

   int n_chk = 0;
   int n_fail = 0;
   int ack_cnt = 0;
   logic [7:0] model [NP][ROW];

   nand_page_engine uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_page(req_page), .req_col(req_col), .req_skip(req_skip),
      .hide_spare(hide_spare), .ready(ready), .ack(ack), .ce_n(ce_n),
      .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (rst_n && ack) ack_cnt <= ack_cnt + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int k);
      return 8'(seed) ^ 8'(k * 7);
   endfunction

   task automatic do_req(input int op, input int page, input int col, input int skip, input bit hide);
      while (!ready) @(negedge clk);
      req_valid  = 1'b1;
      req_op     = 2'(op);
      req_page   = 4'(page);
      req_col    = 10'(col);
      req_skip   = 10'(skip);
      hide_spare = hide;
      @(negedge clk);
      req_valid = 1'b0;
      chk(ready == 1'b0, "R2 busy after request", int'(ready), 0);
      while (!ack) @(negedge clk);
      chk(ready == 1'b1, "R2 ack with ready", int'(ready), 1);
   endtask

   task automatic rd_byte(output logic [7:0] b);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      b = rd_data;
   endtask

   task automatic wr_byte(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_cmp(input int page, input int start, input int count, input string tag);
      int bad = 0;
      int first_act = 0;
      int first_exp = 0;
      logic [7:0] b;
      for (int k = 0; k < count; k++) begin
         rd_byte(b);
         if (b !== model[page][start + k]) begin
            if (bad == 0) begin
               first_act = int'(b);
               first_exp = int'(model[page][start + k]);
            end
            bad++;
         end
      end
      chk(bad == 0, tag, first_act, first_exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] b;
      int cyc;
      int acks_before;
      for (int p = 0; p < NP; p++)
         for (int c = 0; c < ROW; c++) model[p][c] = 8'hFF;

      // reset state
      repeat (3) @(negedge clk);
      chk(ready == 1'b0, "R1 ready low in reset", int'(ready), 0);
      chk(ack == 1'b0, "R2 no ack in reset", int'(ack), 0);
      chk(rd_data == 8'h00, "R11 rd_data reset value", int'(rd_data), 0);
      rst_n = 1'b1;
      cyc = 0;
      while (!ready) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc >= NP * ROW, "R1 fill duration", cyc, NP * ROW);
      chk(ack_cnt == 0, "R1 no ack for fill", ack_cnt, 0);

      // read before any load: nothing remains
      rd_byte(b);
      chk(b == 8'h00, "R9 empty read", int'(b), 0);
      chk(ready == 1'b1, "R10 no reload without load", int'(ready), 1);

      // erased content, full row with spare, then reload of next page
      do_req(0, 0, 0, 0, 1'b0);
      read_cmp(0, 0, ROW, "R1 R7 page 0 reads all 0xFF over row");
      acks_before = ack_cnt;
      rd_byte(b);
      chk(b == 8'h00, "R9 exhausted read", int'(b), 0);
      chk(ready == 1'b0, "R10 reload busy", int'(ready), 0);
      while (!ready) @(negedge clk);
      @(negedge clk);
      chk(ack_cnt == acks_before, "R10 reload gives no ack", ack_cnt, acks_before);
      read_cmp(1, 0, ROW, "R10 reloaded page 1");

      // vector table: fill buffer, program, read back
      for (int v = 0; v < NV; v++) begin
         do_req(3, 0, 0, 0, 1'b0);
         for (int k = 0; k < V_CNT[v]; k++) wr_byte(pat(V_SEED[v], k));
         if (V_PAGE[v] < NP) begin
            for (int k = 0; k < V_CNT[v] && k < ROW; k++)
               if (V_COL[v] + k < ROW)
                  model[V_PAGE[v]][V_COL[v] + k] &= pat(V_SEED[v], k);
         end
         do_req(1, V_PAGE[v], V_COL[v], 0, 1'b0);
         if (V_RB[v] != 0) begin
            do_req(0, V_PAGE[v], V_COL[v], 0, 1'b0);
            read_cmp(V_PAGE[v], V_COL[v], ROW - V_COL[v], "R3 R4 program vector readback");
         end
      end

      // data-only read, then automatic reload of next page
      do_req(0, 5, 0, 0, 1'b1);
      read_cmp(5, 0, PG, "R7 hidden spare length");
      rd_byte(b);
      chk(b == 8'h00, "R7 R9 no byte past data area", int'(b), 0);
      while (!ready) @(negedge clk);
      rd_byte(b);
      chk(b == model[6][0], "R10 next page first byte", int'(b), int'(model[6][0]));

      // column plus skip
      do_req(0, 2, 10, 5, 1'b0);
      read_cmp(2, 15, ROW - 15, "R7 column plus skip");
      rd_byte(b);
      chk(b == 8'h00, "R7 readable count", int'(b), 0);

      // chip enable high consumes nothing
      do_req(0, 2, 0, 0, 1'b0);
      ce_n = 1'b1;
      rd_byte(b);
      chk(b == 8'h00, "R9 ce_n high returns zero", int'(b), 0);
      ce_n = 1'b0;
      rd_byte(b);
      chk(b == model[2][0], "R8 R9 byte not consumed", int'(b), int'(model[2][0]));
      repeat (5) @(negedge clk);
      chk(rd_data == model[2][0], "R11 rd_data held", int'(rd_data), int'(model[2][0]));
      rd_byte(b);
      chk(b == model[2][1], "R8 advance", int'(b), int'(model[2][1]));

      // out-of-range load and erase leave read position and array alone
      do_req(0, 9, 0, 0, 1'b0);
      do_req(2, 12, 0, 0, 1'b0);
      rd_byte(b);
      chk(b == model[2][2], "R6 read position kept", int'(b), int'(model[2][2]));

      // erase aligned block holding pages 2 and 3
      do_req(2, 3, 0, 0, 1'b0);
      for (int p = 2; p < 2 + BLKP; p++)
         for (int c = 0; c < ROW; c++) model[p][c] = 8'hFF;
      do_req(0, 2, 0, 0, 1'b0);
      read_cmp(2, 0, ROW, "R5 lower block page erased");
      do_req(0, 3, 0, 0, 1'b0);
      read_cmp(3, 0, ROW, "R5 upper block page erased");
      do_req(0, 5, 0, 0, 1'b0);
      read_cmp(5, 0, ROW, "R5 R6 other pages kept");

      // last page: no reload beyond the array
      do_req(0, NP - 1, ROW - 4, 0, 1'b0);
      read_cmp(NP - 1, ROW - 4, 4, "R7 tail of last page");
      rd_byte(b);
      chk(b == 8'h00, "R9 last page exhausted", int'(b), 0);
      chk(ready == 1'b1, "R10 no reload past last page", int'(ready), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule